// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the register front end of a four-channel, 8-bit DMA controller. It sits on an 8-bit I/O bus (port address, write strobe, read strobe, write data, read data) and holds everything software programs into the controller. For each channel it keeps a 16-bit start address, a 16-bit transfer count, an 8-bit page, the mode fields and a mask bit. For the controller as a whole it keeps a command byte, the per-channel request flags and a single byte-select toggle. The toggle lets the 16-bit address and count values be written and read back as two byte accesses.

A separate transfer engine consumes the configuration outputs. It raises a request flag through `eng_req`, and it supplies its live address and remaining count so that software can read them back. When software rewrites a channel's address, count or page, the block raises a per-channel "changed" flag. The engine uses this flag to reload its working copy before the next transfer, then acknowledges with `eng_reload`. Bus arbitration and memory cycles belong to the engine and are not part of this block.

Top module: `dma_regif`

## Requirements
- R1: After a synchronous reset, all four masks are set, the command byte, the request flags, the changed flags and `io_rdata` are zero, and the byte toggle selects the low byte.
- R2: Ports 0x00/0x02/0x04/0x06 are channel address ports and 0x01/0x03/0x05/0x07 are channel count ports, with channel = port[2:1]. A write updates the low byte of the 16-bit value when the toggle selects low, and the high byte otherwise.
- R3: Each read or write of an address or count port flips the toggle exactly once. No other access changes it, except the clear port.
- R4: A write of any value to port 0x0C makes the toggle select the low byte.
- R5: A write to port 0x0B programs channel data[1:0] as follows: data[7:6] is the mode (0 demand, 1 single, 2 block, 3 cascade), data[5] is address decrement, data[4] is auto-initialize, and data[3:2] is the transfer type. Other channels keep their fields.
- R6: A write to port 0x0A sets the mask of channel data[1:0] when data[2] is 1 and clears it when data[2] is 0. Masks change by no other means.
- R7: A pulse on `eng_req[c]` sets request flag c. A write to port 0x09 with data[2] = 0 clears the flag of channel data[1:0], and the clear wins over a simultaneous set. With data[2] = 1 the write has no effect. A read of port 0x08 returns the flags in bits 7:4, with channel c at bit 4+c, and zeros in bits 3:0.
- R8: Page ports map to channels as 0x87 to 0, 0x83 to 1, 0x81 to 2, and 0x82 to 3.
- R9: A read of an address port returns a byte of the engine's current address. A read of a count port returns a byte of (engine count − 1) modulo 2^16. In both cases the byte is chosen by the toggle rule of R2.
- R10: A write to a channel's address, count or page port sets that channel's changed flag. `eng_reload[c]` clears the flag, and a write in the same cycle wins.
- R11: A read of any port other than 0x00–0x08 returns 0x00 and changes no state. A write to port 0x08 loads the command byte onto `cmd_cfg`.
- R12: `io_rdata` is registered. It is updated on the edge that samples a read (read strobe high, write strobe low) and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| eng_cur_addr | input | 64 | Engine current address, 16 bits per channel |
| eng_cur_cnt | input | 64 | Engine remaining count, 16 bits per channel |
| eng_req | input | 4 | Per-channel request flag set pulses |
| eng_reload | input | 4 | Per-channel reload acknowledge, clears changed flag |
| cfg_base_addr | output | 64 | Programmed start address, 16 bits per channel |
| cfg_base_cnt | output | 64 | Programmed count, 16 bits per channel |
| cfg_page | output | 32 | Page byte, 8 bits per channel |
| cfg_mode | output | 8 | Mode type, 2 bits per channel |
| cfg_addr_down | output | 4 | Address decrement per channel |
| cfg_autoinit | output | 4 | Auto-initialize enable per channel |
| cfg_xfer | output | 8 | Transfer type, 2 bits per channel |
| cfg_mask | output | 4 | Channel mask bits |
| cfg_changed | output | 4 | Configuration-changed flags |
| cmd_cfg | output | 8 | Command byte |

## Verification
The bound checker watches the byte toggle on every cycle. It must flip after each address or count access, go to low after a clear-port write, and otherwise hold. On every cycle it also checks that mask bits and request flags follow their control writes, that changed flags only rise after a bus write, and that unmapped reads return zero while `io_rdata` holds between reads. Only the bench's scenarios can show the data-dependent results. These include the byte assembly of 16-bit values, the mode field decode, the page-port channel order, the count-minus-one wrap at zero, the set-wins rule on the changed flag, and the status byte layout.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int PAGE_W = 8;
  localparam int BUS_W  = 8;

  localparam logic [7:0] PORT_STATCMD = 8'h08;
  localparam logic [7:0] PORT_REQ     = 8'h09;
  localparam logic [7:0] PORT_MASK    = 8'h0A;
  localparam logic [7:0] PORT_MODE    = 8'h0B;
  localparam logic [7:0] PORT_FFCLR   = 8'h0C;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'd0,
    XM_SINGLE  = 2'd1,
    XM_BLOCK   = 2'd2,
    XM_CASCADE = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e  kind;
    logic        down;
    logic        autoinit;
    logic [1:0]  xfer;
  } mode_cfg_t;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADDR, OP_CNT, OP_STATCMD, OP_REQ,
    OP_MASK, OP_MODE, OP_FFCLR, OP_PAGE
  } port_op_e;

  // Page ports follow a scattered channel order; returns {hit, channel}
  function automatic logic [CH_W:0] page_lookup(input logic [7:0] a);
    case (a)
      8'h87:   page_lookup = {1'b1, 2'd0};
      8'h83:   page_lookup = {1'b1, 2'd1};
      8'h81:   page_lookup = {1'b1, 2'd2};
      8'h82:   page_lookup = {1'b1, 2'd3};
      default: page_lookup = '0;
    endcase
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regif_pkg::*;
(
  input  logic [7:0]      addr,
  output port_op_e        op,
  output logic [CH_W-1:0] ch
);
  logic [CH_W:0] pg;

  always_comb begin
    pg = page_lookup(addr);
    op = OP_NONE;
    ch = addr[CH_W:1];
    if (addr[7:3] == 5'd0) begin
      op = addr[0] ? OP_CNT : OP_ADDR;
    end else begin
      case (addr)
        PORT_STATCMD: op = OP_STATCMD;
        PORT_REQ:     op = OP_REQ;
        PORT_MASK:    op = OP_MASK;
        PORT_MODE:    op = OP_MODE;
        PORT_FFCLR:   op = OP_FFCLR;
        default: begin
          if (pg[CH_W]) begin
            op = OP_PAGE;
            ch = pg[CH_W-1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic              wr_mask,
  input  logic              byte_lo,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              reload,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  base_cnt,
  output logic [PAGE_W-1:0] page,
  output mode_cfg_t         mode,
  output logic              mask,
  output logic              changed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      page      <= '0;
      mode      <= '0;
      mask      <= 1'b1;
      changed   <= 1'b0;
    end else begin
      if (wr_addr) begin
        if (byte_lo) base_addr[7:0]  <= wdata;
        else         base_addr[15:8] <= wdata;
      end
      if (wr_cnt) begin
        if (byte_lo) base_cnt[7:0]  <= wdata;
        else         base_cnt[15:8] <= wdata;
      end
      if (wr_page) page <= wdata[PAGE_W-1:0];
      if (wr_mode) begin
        mode.kind     <= xfer_mode_e'(wdata[7:6]);
        mode.down     <= wdata[5];
        mode.autoinit <= wdata[4];
        mode.xfer     <= wdata[3:2];
      end
      if (wr_mask) mask <= wdata[2];
      // a rewrite in the same cycle as the engine's acknowledge wins
      if (wr_addr || wr_cnt || wr_page) changed <= 1'b1;
      else if (reload)                  changed <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [7:0]               io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [BUS_W-1:0]         io_wdata,
  output logic [BUS_W-1:0]         io_rdata,
  input  logic [NUM_CH*ADDR_W-1:0] eng_cur_addr,
  input  logic [NUM_CH*CNT_W-1:0]  eng_cur_cnt,
  input  logic [NUM_CH-1:0]        eng_req,
  input  logic [NUM_CH-1:0]        eng_reload,
  output logic [NUM_CH*ADDR_W-1:0] cfg_base_addr,
  output logic [NUM_CH*CNT_W-1:0]  cfg_base_cnt,
  output logic [NUM_CH*PAGE_W-1:0] cfg_page,
  output logic [NUM_CH*2-1:0]      cfg_mode,
  output logic [NUM_CH-1:0]        cfg_addr_down,
  output logic [NUM_CH-1:0]        cfg_autoinit,
  output logic [NUM_CH*2-1:0]      cfg_xfer,
  output logic [NUM_CH-1:0]        cfg_mask,
  output logic [NUM_CH-1:0]        cfg_changed,
  output logic [BUS_W-1:0]         cmd_cfg
);
  localparam int REQ_LSB = BUS_W - NUM_CH;

  port_op_e         op;
  logic [CH_W-1:0]  op_ch;
  logic             byte_lo;
  logic [NUM_CH-1:0] req_q;
  logic             wide_acc;
  logic [BUS_W-1:0] rd_val;
  logic [ADDR_W-1:0] sel_addr;
  logic [CNT_W-1:0]  sel_cnt_m1;

  dma_port_decode u_dec (
    .addr (io_addr),
    .op   (op),
    .ch   (op_ch)
  );

  assign wide_acc = (io_wr || io_rd) && (op == OP_ADDR || op == OP_CNT);

  // shared low/high byte selector
  always_ff @(posedge clk) begin
    if (rst)                            byte_lo <= 1'b1;
    else if (io_wr && op == OP_FFCLR)   byte_lo <= 1'b1;
    else if (wide_acc)                  byte_lo <= ~byte_lo;
  end

  always_ff @(posedge clk) begin
    if (rst)                             cmd_cfg <= '0;
    else if (io_wr && op == OP_STATCMD)  cmd_cfg <= io_wdata;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mode_cfg_t m;
    logic hit_bus, hit_dat;

    assign hit_bus = io_wr && (op_ch == CH_W'(c));
    assign hit_dat = io_wr && (io_wdata[CH_W-1:0] == CH_W'(c));

    dma_chan_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_addr   (hit_bus && op == OP_ADDR),
      .wr_cnt    (hit_bus && op == OP_CNT),
      .wr_page   (hit_bus && op == OP_PAGE),
      .wr_mode   (hit_dat && op == OP_MODE),
      .wr_mask   (hit_dat && op == OP_MASK),
      .byte_lo   (byte_lo),
      .wdata     (io_wdata),
      .reload    (eng_reload[c]),
      .base_addr (cfg_base_addr[c*ADDR_W +: ADDR_W]),
      .base_cnt  (cfg_base_cnt[c*CNT_W +: CNT_W]),
      .page      (cfg_page[c*PAGE_W +: PAGE_W]),
      .mode      (m),
      .mask      (cfg_mask[c]),
      .changed   (cfg_changed[c])
    );

    assign cfg_mode[c*2 +: 2] = m.kind;
    assign cfg_addr_down[c]   = m.down;
    assign cfg_autoinit[c]    = m.autoinit;
    assign cfg_xfer[c*2 +: 2] = m.xfer;

    // request flags: clear through the bus beats the engine's set
    always_ff @(posedge clk) begin
      if (rst)                                        req_q[c] <= 1'b0;
      else if (hit_dat && op == OP_REQ && !io_wdata[2]) req_q[c] <= 1'b0;
      else if (eng_req[c])                            req_q[c] <= 1'b1;
    end
  end

  always_comb begin
    sel_addr   = eng_cur_addr[op_ch*ADDR_W +: ADDR_W];
    sel_cnt_m1 = eng_cur_cnt[op_ch*CNT_W +: CNT_W] - CNT_W'(1);
    case (op)
      OP_ADDR:    rd_val = byte_lo ? sel_addr[7:0]   : sel_addr[15:8];
      OP_CNT:     rd_val = byte_lo ? sel_cnt_m1[7:0] : sel_cnt_m1[15:8];
      OP_STATCMD: rd_val = {req_q, {REQ_LSB{1'b0}}};
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  io_rdata <= '0;
    else if (io_rd && !io_wr) io_rdata <= rd_val;
  end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk
  import dma_regif_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [7:0]        io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [BUS_W-1:0]  io_wdata,
  input logic [BUS_W-1:0]  io_rdata,
  input logic [NUM_CH-1:0] cfg_mask,
  input logic [NUM_CH-1:0] cfg_changed,
  input logic [NUM_CH-1:0] req_q,
  input logic              byte_lo
);
  logic wide, clr_wr, unmapped_rd;
  assign wide        = (io_wr || io_rd) && (io_addr[7:3] == 5'd0);
  assign clr_wr      = io_wr && (io_addr == PORT_FFCLR);
  assign unmapped_rd = io_rd && !io_wr && (io_addr[7:3] != 5'd0) && (io_addr != PORT_STATCMD);

  // R4
  ffclr_low_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> byte_lo);
  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wide && !clr_wr) |=> (byte_lo != $past(byte_lo)));
  // R3
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wide && !clr_wr) |=> $stable(byte_lo));
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == PORT_MASK) |=> $stable(cfg_mask));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped_rd |=> (io_rdata == '0));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R6
    mask_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr == PORT_MASK && io_wdata[CH_W-1:0] == CH_W'(c))
        |=> (cfg_mask[c] == $past(io_wdata[2])));
    // R7
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr == PORT_REQ && !io_wdata[2] && io_wdata[CH_W-1:0] == CH_W'(c))
        |=> !req_q[c]);
    // R10
    changed_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_changed[c]) |-> $past(io_wr));
  end
endmodule

bind dma_regif dma_regif_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .cfg_mask    (cfg_mask),
  .cfg_changed (cfg_changed),
  .req_q       (req_q),
  .byte_lo     (byte_lo)
);

// File: tb/tb_dma_regif.sv
module tb_dma_regif;
  import dma_regif_pkg::*;

  logic clk = 0;
  logic rst = 1;
  logic [7:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic [63:0] eng_cur_addr = 0, eng_cur_cnt = 0;
  logic [3:0] eng_req = 0, eng_reload = 0;
  logic [63:0] cfg_base_addr, cfg_base_cnt;
  logic [31:0] cfg_page;
  logic [7:0] cfg_mode, cfg_xfer, cmd_cfg;
  logic [3:0] cfg_addr_down, cfg_autoinit, cfg_mask, cfg_changed;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dma_regif dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mask", cfg_mask, 4'hF);
    chk("R1 changed", cfg_changed, 0);
    chk("R1 cmd", cmd_cfg, 0);
    chk("R1 rdata", io_rdata, 0);
    rd(8'h08, d);
    chk("R1 status", d, 0);
    wr(8'h00, 8'h5C);
    chk("R1 toggle low", cfg_base_addr[15:0], 16'h005C);
    wr(8'h00, 8'h00);
  endtask

  task automatic t_addr_cnt;
    wr(8'h0C, 8'hFF);
    wr(8'h02, 8'h34); wr(8'h02, 8'h12);
    chk("R2 addr ch1", cfg_base_addr[31:16], 16'h1234);
    chk("R10 changed ch1", cfg_changed[1], 1);
    // R3: toggle is back on low without a clear
    wr(8'h07, 8'hCD); wr(8'h07, 8'hAB);
    chk("R3 cnt ch3", cfg_base_cnt[63:48], 16'hABCD);
    chk("R2 other ch untouched", cfg_base_cnt[47:32], 16'h0000);
  endtask

  task automatic t_clear;
    wr(8'h0C, 8'h00);
    wr(8'h04, 8'h11);
    wr(8'h0C, 8'h00);
    wr(8'h04, 8'h22); wr(8'h04, 8'h33);
    chk("R4 clear mid pair", cfg_base_addr[47:32], 16'h3322);
  endtask

  task automatic t_mode;
    wr(8'h0B, 8'hB9);
    chk("R5 mode ch1", cfg_mode[3:2], 2);
    chk("R5 down ch1", cfg_addr_down[1], 1);
    chk("R5 autoinit ch1", cfg_autoinit[1], 1);
    chk("R5 xfer ch1", cfg_xfer[3:2], 2);
    chk("R5 ch0 untouched", {cfg_mode[1:0], cfg_xfer[1:0], cfg_autoinit[0]}, 0);
  endtask

  task automatic t_mask;
    wr(8'h0A, 8'h02);
    chk("R6 clear ch2", cfg_mask, 4'b1011);
    wr(8'h0A, 8'h06);
    chk("R6 set ch2", cfg_mask, 4'b1111);
  endtask

  task automatic t_page;
    @(negedge clk); eng_reload = 4'hF;
    @(negedge clk); eng_reload = 0;
    chk("R10 reload clears", cfg_changed, 0);
    wr(8'h81, 8'hA2);
    chk("R8 page 0x81 ch2", cfg_page[23:16], 8'hA2);
    chk("R10 page sets changed", cfg_changed, 4'b0100);
    wr(8'h87, 8'hA0); wr(8'h83, 8'hA1); wr(8'h82, 8'hA3);
    chk("R8 page map", cfg_page, 32'hA3A2A1A0);
    @(negedge clk); eng_reload = 4'hF;
    @(negedge clk); eng_reload = 0;
    // R10: write and reload in the same cycle, write wins
    @(negedge clk); io_addr = 8'h87; io_wdata = 8'h55; io_wr = 1; eng_reload = 4'h1;
    @(negedge clk); io_wr = 0; eng_reload = 0;
    chk("R10 set wins", cfg_changed, 4'b0001);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    eng_cur_addr[47:32] = 16'h5A3C;
    eng_cur_cnt[47:32]  = 16'h0100;
    eng_cur_cnt[15:0]   = 16'h0000;
    wr(8'h0C, 0);
    rd(8'h04, d); chk("R9 addr lo", d, 8'h3C);
    rd(8'h04, d); chk("R9 addr hi", d, 8'h5A);
    rd(8'h05, d); chk("R9 cnt-1 lo", d, 8'hFF);
    rd(8'h05, d); chk("R9 cnt-1 hi", d, 8'h00);
    rd(8'h01, d); chk("R9 zero count wraps lo", d, 8'hFF);
    rd(8'h01, d); chk("R9 zero count wraps hi", d, 8'hFF);
    @(negedge clk);
    chk("R12 rdata holds", io_rdata, 8'hFF);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); eng_req = 4'b1010;
    @(negedge clk); eng_req = 0;
    rd(8'h08, d); chk("R7 status", d, 8'hA0);
    wr(8'h09, 8'h03);
    rd(8'h08, d); chk("R7 clear ch3", d, 8'h20);
    wr(8'h09, 8'h07);
    rd(8'h08, d); chk("R7 bit2 set no effect", d, 8'h20);
    // R7: clear and set same cycle, clear wins
    @(negedge clk); io_addr = 8'h09; io_wdata = 8'h01; io_wr = 1; eng_req = 4'b0010;
    @(negedge clk); io_wr = 0; eng_req = 0;
    rd(8'h08, d); chk("R7 clear wins", d, 8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h0C, 0);
    rd(8'h0F, d); chk("R11 unmapped zero", d, 8'h00);
    rd(8'h0B, d); chk("R11 mode port reads zero", d, 8'h00);
    rd(8'h04, d); chk("R11 toggle untouched", d, 8'h3C);
    wr(8'h08, 8'h04);
    chk("R11 command", cmd_cfg, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_addr_cnt;
    t_clear;
    t_mode;
    t_mask;
    t_page;
    t_readback;
    t_status;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule